// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block derives the six arithmetic status flags (carry, parity, auxiliary carry, zero, sign, overflow) of an ALU operation at byte, word or doubleword width. It works from the two operands, the operation class and the result the ALU already produced. It keeps these flags in a registered status word, together with three control bits: a string-direction bit, an interrupt-enable bit and a single-step bit. Arithmetic never touches the control bits; only an explicit set/clear command writes them.

The 16-bit status word is always visible at the output. A 4-bit condition code port evaluates a branch condition from the stored flags in the same cycle, so a conditional jump can query it directly. The datapath width is a parameter (8, 16 or 32). Size codes wider than the datapath fall back to the widest supported width.

Carry and overflow are taken from the sign bits of the operands and of the result. No second adder is needed. For add-with-carry and subtract-with-borrow, the ALU folds the stored carry into the result it supplies.

Top module: `arith_flag_unit`

## Requirements
- R1: Carry (bit 0) is the carry out of the top bit of the active width for add/add-with-carry (alu_op 0/1), and the borrow into it for subtract/subtract-with-borrow (alu_op 2/3).
- R2: Overflow (bit 11) is set when the signed result does not fit in the active width.
- R3: Sign (bit 7) is the top bit of the result at the active width. Zero (bit 6) is set when the result at the active width is all zeros. Bits above the active width of operands and result are ignored.
- R4: Auxiliary carry (bit 4) is the carry out of, or borrow into, bit 3 of the low byte for arithmetic operations.
- R5: Parity (bit 2) is set when the low result byte holds an even number of ones, at every width.
- R6: For add-with-carry and subtract-with-borrow, every flag is consistent with a result that includes the carry flag stored before the update.
- R7: Logical operations (alu_op 4 to 7) clear carry and overflow, update sign, zero and parity, and leave auxiliary carry unchanged.
- R8: Control bits direction (bit 10), interrupt-enable (bit 9) and single-step (bit 8) change only when ctl_en is high. ctl_sel 0/1/2 selects direction/interrupt/step, the bit takes ctl_val, and ctl_sel 3 writes nothing. Arithmetic updates leave them unchanged.
- R9: Bit 1 of the word reads 1 and bits 3, 5 and 15:12 read 0. Reset gives the word 16'h0002.
- R10: With upd_en low, the arithmetic flags keep their value whatever the operand inputs do.
- R11: cond_true evaluates cond_code from the stored flags in the same cycle. The codes are: 0 OF, 1 !OF, 2 CF, 3 !CF, 4 ZF, 5 !ZF, 6 CF|ZF, 7 !(CF|ZF), 8 SF, 9 !SF, 10 PF, 11 !PF, 12 SF!=OF, 13 SF==OF, 14 ZF|(SF!=OF), 15 !(ZF|(SF!=OF)).
- R12: op_size 0/1/2 selects 8/16/32 bits. A size wider than DATA_W acts as DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Capture arithmetic flags this cycle |
| alu_op | input | 3 | 0 add, 1 add-with-carry, 2 sub, 3 sub-with-borrow, 4..7 logical |
| op_size | input | 2 | 0 byte, 1 word, 2 doubleword |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand (subtrahend) |
| alu_result | input | DATA_W | Result produced by the ALU |
| ctl_en | input | 1 | Control bit write strobe |
| ctl_sel | input | 2 | Control bit select |
| ctl_val | input | 1 | Value written to the selected control bit |
| cond_code | input | 4 | Branch condition to evaluate |
| flags_word | output | 16 | Full status word |
| cond_true | output | 1 | Result of the condition evaluation |

## Verification
The bench builds the block with DATA_W=16. This puts both the byte and word paths in reach, along with the fallback of size code 2 to 16 bits. Byte-wide arithmetic is swept over every second operand against sixteen spread first operands for all four arithmetic classes. This covers every carry, half-carry, overflow and parity pattern, and the upper bits of the operands are filled with junk. Word-width corner operands exercise the 16-bit sign and carry positions. The condition code rotates through all sixteen values as the flags change.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;

   localparam logic [2:0] OP_ADD = 3'd0;
   localparam logic [2:0] OP_ADC = 3'd1;
   localparam logic [2:0] OP_SUB = 3'd2;
   localparam logic [2:0] OP_SBB = 3'd3;

   localparam logic [1:0] CTL_DIR  = 2'd0;
   localparam logic [1:0] CTL_INTR = 2'd1;
   localparam logic [1:0] CTL_STEP = 2'd2;

   localparam int unsigned BIT_CF   = 0;
   localparam int unsigned BIT_ONE  = 1;
   localparam int unsigned BIT_PF   = 2;
   localparam int unsigned BIT_AF   = 4;
   localparam int unsigned BIT_ZF   = 6;
   localparam int unsigned BIT_SF   = 7;
   localparam int unsigned BIT_STEP = 8;
   localparam int unsigned BIT_INTR = 9;
   localparam int unsigned BIT_DIR  = 10;
   localparam int unsigned BIT_OF   = 11;

   typedef struct packed {
      logic of;
      logic sf;
      logic zf;
      logic af;
      logic pf;
      logic cf;
   } arith_flags_t;

   typedef struct packed {
      logic dir;
      logic intr;
      logic step;
   } ctl_flags_t;

endpackage

// File: rtl/arith_flag_calc.sv
module arith_flag_calc
   import arith_flag_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [2:0]        alu_op,
   input  logic [1:0]        op_size,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] alu_result,
   output arith_flags_t      flags_nxt,
   output logic              af_hold
);

   localparam int unsigned NUM_W   = (DATA_W == 32) ? 3 : (DATA_W == 16) ? 2 : 1;
   localparam int unsigned TOP_IDX = NUM_W - 1;

   if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32)) begin : g_bad_width
      $error("arith_flag_calc: DATA_W must be 8, 16 or 32");
   end

   logic is_sub;
   logic is_logic;
   assign is_sub   = (alu_op == OP_SUB) || (alu_op == OP_SBB);
   assign is_logic = (alu_op > OP_SBB);

   logic [NUM_W-1:0] cf_v;
   logic [NUM_W-1:0] of_v;
   logic [NUM_W-1:0] sf_v;
   logic [NUM_W-1:0] zf_v;

   for (genvar g = 0; g < NUM_W; g++) begin : g_width
      localparam int unsigned W = 8 << g;
      logic a_top;
      logic b_top;
      logic r_top;
      assign a_top = opnd_a[W-1];
      assign b_top = opnd_b[W-1];
      assign r_top = alu_result[W-1];
      assign sf_v[g] = r_top;
      assign zf_v[g] = (alu_result[W-1:0] == '0);
      // carry into the top bit equals a^b^r there; fold it into the out-carry
      assign cf_v[g] = is_sub ? ((~a_top & b_top) | (~(a_top ^ b_top) & r_top))
                              : ((a_top & b_top) | ((a_top ^ b_top) & ~r_top));
      assign of_v[g] = is_sub ? ((a_top ^ b_top) & (a_top ^ r_top))
                              : (~(a_top ^ b_top) & (a_top ^ r_top));
   end

   int unsigned sel_w;
   always_comb begin
      sel_w = TOP_IDX;
      if (32'(op_size) < TOP_IDX) sel_w = 32'(op_size);
   end

   logic cf_s;
   logic of_s;
   logic sf_s;
   logic zf_s;
   always_comb begin
      cf_s = cf_v[0];
      of_s = of_v[0];
      sf_s = sf_v[0];
      zf_s = zf_v[0];
      for (int unsigned i = 1; i < NUM_W; i++) begin
         if (sel_w == i) begin
            cf_s = cf_v[i];
            of_s = of_v[i];
            sf_s = sf_v[i];
            zf_s = zf_v[i];
         end
      end
   end

   always_comb begin
      flags_nxt.sf = sf_s;
      flags_nxt.zf = zf_s;
      flags_nxt.pf = ~^alu_result[7:0];
      flags_nxt.af = opnd_a[4] ^ opnd_b[4] ^ alu_result[4];
      flags_nxt.cf = is_logic ? 1'b0 : cf_s;
      flags_nxt.of = is_logic ? 1'b0 : of_s;
   end

   assign af_hold = is_logic;

endmodule

// File: rtl/arith_flag_store.sv
module arith_flag_store
   import arith_flag_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_en,
   input  arith_flags_t flags_nxt,
   input  logic         af_hold,
   input  logic         ctl_en,
   input  logic [1:0]   ctl_sel,
   input  logic         ctl_val,
   output arith_flags_t arith_q,
   output ctl_flags_t   ctl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arith_q <= '0;
      end else if (upd_en) begin
         arith_q.cf <= flags_nxt.cf;
         arith_q.pf <= flags_nxt.pf;
         arith_q.zf <= flags_nxt.zf;
         arith_q.sf <= flags_nxt.sf;
         arith_q.of <= flags_nxt.of;
         if (!af_hold) arith_q.af <= flags_nxt.af;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_en) begin
         case (ctl_sel)
            CTL_DIR:  ctl_q.dir  <= ctl_val;
            CTL_INTR: ctl_q.intr <= ctl_val;
            CTL_STEP: ctl_q.step <= ctl_val;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/arith_cond_eval.sv
module arith_cond_eval
   import arith_flag_pkg::*;
(
   input  arith_flags_t fl,
   input  logic [3:0]   cond_code,
   output logic         cond_true
);

   logic base;
   logic lt;
   assign lt = fl.sf ^ fl.of;

   always_comb begin
      case (cond_code[3:1])
         3'd0:    base = fl.of;
         3'd1:    base = fl.cf;
         3'd2:    base = fl.zf;
         3'd3:    base = fl.cf | fl.zf;
         3'd4:    base = fl.sf;
         3'd5:    base = fl.pf;
         3'd6:    base = lt;
         default: base = fl.zf | lt;
      endcase
   end

   // odd codes are the negation of the even code below them
   assign cond_true = base ^ cond_code[0];

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
   import arith_flag_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [2:0]        alu_op,
   input  logic [1:0]        op_size,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] alu_result,
   input  logic              ctl_en,
   input  logic [1:0]        ctl_sel,
   input  logic              ctl_val,
   input  logic [3:0]        cond_code,
   output logic [15:0]       flags_word,
   output logic              cond_true
);

   arith_flags_t flags_nxt;
   arith_flags_t arith_q;
   ctl_flags_t   ctl_q;
   logic         af_hold;

   arith_flag_calc #(.DATA_W(DATA_W)) u_calc (
      .alu_op     (alu_op),
      .op_size    (op_size),
      .opnd_a     (opnd_a),
      .opnd_b     (opnd_b),
      .alu_result (alu_result),
      .flags_nxt  (flags_nxt),
      .af_hold    (af_hold)
   );

   arith_flag_store u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (upd_en),
      .flags_nxt (flags_nxt),
      .af_hold   (af_hold),
      .ctl_en    (ctl_en),
      .ctl_sel   (ctl_sel),
      .ctl_val   (ctl_val),
      .arith_q   (arith_q),
      .ctl_q     (ctl_q)
   );

   arith_cond_eval u_cond (
      .fl        (arith_q),
      .cond_code (cond_code),
      .cond_true (cond_true)
   );

   always_comb begin
      flags_word           = '0;
      flags_word[BIT_ONE]  = 1'b1;
      flags_word[BIT_CF]   = arith_q.cf;
      flags_word[BIT_PF]   = arith_q.pf;
      flags_word[BIT_AF]   = arith_q.af;
      flags_word[BIT_ZF]   = arith_q.zf;
      flags_word[BIT_SF]   = arith_q.sf;
      flags_word[BIT_STEP] = ctl_q.step;
      flags_word[BIT_INTR] = ctl_q.intr;
      flags_word[BIT_DIR]  = ctl_q.dir;
      flags_word[BIT_OF]   = arith_q.of;
   end

endmodule

// File: rtl/arith_flag_unit_chk.sv
module arith_flag_unit_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_en,
   input logic [2:0]        alu_op,
   input logic [DATA_W-1:0] alu_result,
   input logic              ctl_en,
   input logic [1:0]        ctl_sel,
   input logic              ctl_val,
   input logic [3:0]        cond_code,
   input logic [15:0]       flags_word,
   input logic              cond_true
);

   a_r8_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> flags_word[10:8] == $past(flags_word[10:8]));

   a_r8_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && ctl_sel == 2'd0) |=> flags_word[10] == $past(ctl_val));

   a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && alu_op >= 3'd4) |=> (!flags_word[0] && !flags_word[11]));

   a_r7_af_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && alu_op >= 3'd4) |=> $stable(flags_word[4]));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !ctl_en) |=> $stable(flags_word));

   a_r5_parity: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> flags_word[2] == ~^$past(alu_result[7:0]));

   a_r9_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      flags_word[1] && !flags_word[3] && !flags_word[5] && flags_word[15:12] == 4'd0);

   a_r11_equal: assert property (@(posedge clk) disable iff (!rst_n)
      cond_code == 4'd4 |-> cond_true == flags_word[6]);

endmodule

bind arith_flag_unit arith_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_en     (upd_en),
   .alu_op     (alu_op),
   .alu_result (alu_result),
   .ctl_en     (ctl_en),
   .ctl_sel    (ctl_sel),
   .ctl_val    (ctl_val),
   .cond_code  (cond_code),
   .flags_word (flags_word),
   .cond_true  (cond_true)
);

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;

   localparam int unsigned DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          upd_en = 1'b0;
   logic [2:0]    alu_op = '0;
   logic [1:0]    op_size = '0;
   logic [DW-1:0] opnd_a = '0;
   logic [DW-1:0] opnd_b = '0;
   logic [DW-1:0] alu_result = '0;
   logic          ctl_en = 1'b0;
   logic [1:0]    ctl_sel = '0;
   logic          ctl_val = 1'b0;
   logic [3:0]    cond_code = '0;
   logic [15:0]   flags_word;
   logic          cond_true;

   always #5 clk = ~clk;

   arith_flag_unit #(.DATA_W(DW)) u_arith_flag_unit (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .alu_op(alu_op), .op_size(op_size),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_result(alu_result), .ctl_en(ctl_en),
      .ctl_sel(ctl_sel), .ctl_val(ctl_val), .cond_code(cond_code),
      .flags_word(flags_word), .cond_true(cond_true)
   );

   int n_chk = 0;
   int n_err = 0;
   int cc_rot = 0;
   logic done = 1'b0;

   logic m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
   logic m_dir = 0, m_intr = 0, m_step = 0;

   function automatic logic [15:0] mword();
      logic [15:0] w;
      w = 16'h0002;
      w[0] = m_cf; w[2] = m_pf; w[4] = m_af; w[6] = m_zf; w[7] = m_sf;
      w[8] = m_step; w[9] = m_intr; w[10] = m_dir; w[11] = m_of;
      return w;
   endfunction

   function automatic logic exp_cond(input logic [3:0] c);
      case (c)
         4'd0:  return m_of;
         4'd1:  return !m_of;
         4'd2:  return m_cf;
         4'd3:  return !m_cf;
         4'd4:  return m_zf;
         4'd5:  return !m_zf;
         4'd6:  return m_cf || m_zf;
         4'd7:  return !(m_cf || m_zf);
         4'd8:  return m_sf;
         4'd9:  return !m_sf;
         4'd10: return m_pf;
         4'd11: return !m_pf;
         4'd12: return m_sf != m_of;
         4'd13: return m_sf == m_of;
         4'd14: return m_zf || (m_sf != m_of);
         default: return !(m_zf || (m_sf != m_of));
      endcase
   endfunction

   task automatic chk_bit(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic chk_word(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%04h expected=%04h", tag, act, exp);
      end
   endtask

   // called at a negedge; drives one update and checks at the following negedge
   task automatic run_arith(input int op, input int sz, input longint a, input longint b);
      int w;
      longint mask, half, cin, full, r, sa, sb, so;
      bit sub_t, log_t;
      w = (sz == 0) ? 8 : 16;
      mask = (64'sd1 <<< w) - 1;
      half = 64'sd1 <<< (w - 1);
      a = a & mask;
      b = b & mask;
      sub_t = (op == 2 || op == 3);
      log_t = (op >= 4);
      cin = ((op == 1 || op == 3) && m_cf) ? 1 : 0;
      sa = (a >= half) ? a - (64'sd1 <<< w) : a;
      sb = (b >= half) ? b - (64'sd1 <<< w) : b;
      if (log_t) begin
         r = (a ^ b) & mask;
         m_cf = 1'b0;
         m_of = 1'b0;
      end else if (sub_t) begin
         full = a - b - cin;
         r = full & mask;
         so = sa - sb - cin;
         m_cf = (a < b + cin);
         m_af = ((a & 15) < (b & 15) + cin);
         m_of = (so >= half) || (so < -half);
      end else begin
         full = a + b + cin;
         r = full & mask;
         so = sa + sb + cin;
         m_cf = ((full >>> w) & 1) != 0;
         m_af = ((a & 15) + (b & 15) + cin) > 15;
         m_of = (so >= half) || (so < -half);
      end
      m_zf = (r == 0);
      m_sf = ((r >>> (w - 1)) & 1) != 0;
      m_pf = ~^r[7:0];
      upd_en = 1'b1;
      alu_op = 3'(op);
      op_size = 2'(sz);
      opnd_a = a[15:0];
      opnd_b = b[15:0];
      alu_result = r[15:0];
      if (w == 8) begin
         // junk above the active byte must be ignored (R3)
         opnd_a[15:8] = 8'h5A;
         opnd_b[15:8] = 8'hC3;
         alu_result[15:8] = 8'hA5;
      end
      cond_code = 4'(cc_rot);
      cc_rot++;
      @(negedge clk);
      upd_en = 1'b0;
      chk_bit("R1 carry", flags_word[0], m_cf);
      chk_bit("R2 overflow", flags_word[11], m_of);
      chk_bit("R3 sign", flags_word[7], m_sf);
      chk_bit("R3 zero", flags_word[6], m_zf);
      chk_bit(log_t ? "R7 aux kept" : "R4 aux carry", flags_word[4], m_af);
      chk_bit("R5 parity", flags_word[2], m_pf);
      chk_word("R8/R9 whole word", flags_word, mword());
      chk_bit("R11 condition", cond_true, exp_cond(cond_code));
   endtask

   task automatic set_ctl(input int sel, input logic val);
      ctl_en = 1'b1;
      ctl_sel = 2'(sel);
      ctl_val = val;
      if (sel == 0) m_dir = val;
      if (sel == 1) m_intr = val;
      if (sel == 2) m_step = val;
      @(negedge clk);
      ctl_en = 1'b0;
      chk_word("R8 control write", flags_word, mword());
   endtask

   initial begin
      longint pa [6] = '{64'h0000, 64'hFFFF, 64'h7FFF, 64'h8000, 64'h00FF, 64'h8001};
      longint pb [6] = '{64'h0000, 64'h0001, 64'h0001, 64'h8000, 64'h0001, 64'h7FFF};
      repeat (3) @(negedge clk);
      chk_word("R9 reset value", flags_word, 16'h0002);
      rst_n = 1'b1;
      @(negedge clk);
      chk_word("R9 after reset release", flags_word, 16'h0002);

      set_ctl(0, 1'b1);
      set_ctl(1, 1'b1);
      set_ctl(2, 1'b1);
      set_ctl(3, 1'b0);

      for (int op = 0; op < 4; op++)
         for (int ai = 0; ai < 16; ai++)
            for (int bv = 0; bv < 256; bv++)
               run_arith(op, 0, longint'(ai * 17), longint'(bv));

      for (int av = 0; av < 256; av++)
         for (int bi = 0; bi < 16; bi++)
            run_arith(4 + (av % 4), 0, longint'(av), longint'(bi * 17));

      set_ctl(1, 1'b0);
      for (int op = 0; op < 5; op++)
         for (int sz = 1; sz < 3; sz++)   // sz 2 acts as 16 bits (R12)
            for (int k = 0; k < 6; k++)
               run_arith(op, sz, pa[k], pb[k]);

      // R12: same operands at size 2 and size 1 give identical flags
      run_arith(0, 2, 64'h7FFF, 64'h0001);
      chk_bit("R12 size clamp overflow", flags_word[11], 1'b1);

      // R6: carry-in folded into adc/sbb
      run_arith(0, 0, 64'hFF, 64'h01);
      chk_bit("R6 carry set before adc", flags_word[0], 1'b1);
      run_arith(1, 0, 64'h00, 64'h00);
      chk_bit("R6 adc result one not zero", flags_word[6], 1'b0);
      run_arith(2, 0, 64'h00, 64'h01);
      run_arith(3, 0, 64'h01, 64'h00);
      chk_bit("R6 sbb with borrow gives zero", flags_word[6], 1'b1);

      // R10: inputs move with upd_en low
      run_arith(0, 0, 64'h80, 64'h80);
      upd_en = 1'b0;
      alu_op = 3'd2;
      opnd_a = 16'h0001;
      opnd_b = 16'h0002;
      alu_result = 16'hFFFF;
      @(negedge clk);
      @(negedge clk);
      chk_word("R10 hold without enable", flags_word, mword());

      // R7: logical op keeps aux carry that arithmetic set
      run_arith(0, 0, 64'h0F, 64'h01);
      chk_bit("R7 aux set by add", flags_word[4], 1'b1);
      run_arith(4, 0, 64'hF0, 64'h0F);
      chk_bit("R7 aux kept by logic", flags_word[4], 1'b1);
      chk_bit("R7 carry cleared", flags_word[0], 1'b0);

      // R9: asynchronous reset in mid-run
      rst_n = 1'b0;
      #1;
      chk_word("R9 reset mid-run", flags_word, 16'h0002);
      @(negedge clk);
      rst_n = 1'b1;
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule